// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus interface state machine of an 8-bit processor that shares its low address byte and its data byte on one set of lines. The core asks for one bus transaction at a time. The kinds are opcode fetch, memory read, memory write, port read and port write. The block then steps through T-states, each two input clocks long. In each T-state it drives the address strobe, the read and write strobes, the three status lines, the high address byte with its enable, and the multiplexed byte as separate value and enable signals.

For a read, the byte on the shared lines is captured at the end of the third T-state. A one-clock completion pulse follows the last T-state, and the captured byte is valid with that pulse. An opcode fetch adds a decode state, or three extra internal states when the request marks it as extended. Port transactions carry an 8-bit port number, which appears on both address bytes.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the block is idle: busy_o=0, done_o=0, ale_o=0, rd_no=1, wr_no=1, ad_oe_o=0, addr_hi_oe_o=0 and {io_m_o,s1_o,s0_o}=000.
- R2: Each T-state lasts two clocks. If a request is accepted at clock edge 0, T-state k occupies clocks 2k-1 and 2k. ale_o is high in both clocks of T1 and low at all other times.
- R3: During T1, ad_oe_o=1 and ad_o carries address bits 7:0. addr_hi_oe_o is high from T1 through T3 only. For memory kinds, addr_hi_o carries address bits 15:8 while that enable is high.
- R4: Kind codes on req_kind_i are 0 fetch, 1 memory read, 2 memory write, 3 port read and 4 port write. {io_m_o,s1_o,s0_o} is 011, 010, 001, 110 and 101 for these kinds. The value is driven from T1 through the final T-state and is 000 while idle.
- R5: A fetch lasts 4 T-states, or 6 when req_long_i=1. Every other kind lasts 3. While the transaction runs, busy_o=1, and it returns to 0 in the clock that follows the final T-state.
- R6: For read kinds (0, 1, 3), ad_oe_o=0 and rd_no=0 throughout T2 and T3, and rd_no=1 at all other times. rdata_o takes the value of ad_i at the clock edge that ends T3.
- R7: For write kinds (2, 4), ad_o carries the write data with ad_oe_o=1 throughout T2 and T3. wr_no is low in the second clock of T2 and in both clocks of T3, and high at all other times.
- R8: For port kinds (3, 4), address bits 7:0 are the port number. That number is driven on ad_o in T1 and on addr_hi_o from T1 to T3, whatever address bits 15:8 hold.
- R9: A request is accepted only when busy_o=0 and req_kind_i is 0 to 4. A request made while busy, or one with kind 5 to 7, has no effect.
- R10: done_o is high for exactly one clock, the clock after the final T-state. rdata_o keeps its value until the next read captures a new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_kind_i | input | 3 | Transaction kind code |
| req_addr_i | input | 16 | Memory address, or port number in bits 7:0 |
| req_wdata_i | input | 8 | Write data |
| req_long_i | input | 1 | Extended opcode fetch |
| busy_o | output | 1 | Transaction in progress |
| ale_o | output | 1 | Address latch strobe |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | Port/memory status |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| addr_hi_o | output | 8 | High address byte |
| addr_hi_oe_o | output | 1 | High address byte drive enable |
| ad_o | output | 8 | Multiplexed address/data byte out |
| ad_oe_o | output | 1 | Multiplexed byte drive enable |
| ad_i | input | 8 | Multiplexed byte in |
| rdata_o | output | 8 | Captured read byte |
| done_o | output | 1 | Completion pulse |

## Verification
Clocks are counted from the edge that accepts a request. T-state k is expected in clocks 2k-1 and 2k. The completion pulse and the captured byte are expected in clock 2n+1 of an n-state transaction, and the pulse is gone again in clock 2n+2. The read byte is sampled at the edge that ends clock 6. The bench puts the correct byte on ad_i only for that one clock, so a capture one edge early or late reads the complemented byte. Each directed task walks every clock of its transaction at the falling edge and compares each output with the value computed for that clock index.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } status_t;

  function automatic logic kind_ok(logic [2:0] k);
    return k <= 3'd4;
  endfunction
endpackage

// File: rtl/mbs_tick.sv
module mbs_tick #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic first_o,
  output logic last_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_nodiv
      assign first_o = 1'b1;
      assign last_o  = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          cnt_q <= '0;
        else if (!run_i)                      cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))       cnt_q <= '0;
        else                                  cnt_q <= cnt_q + 1'b1;
      end
      assign first_o = (cnt_q == '0);
      assign last_o  = (cnt_q == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/mbs_decode.sv
module mbs_decode
  import mbs_pkg::*;
(
  input  logic [2:0] kind_i,
  input  logic       long_i,
  output status_t    status_o,
  output logic       is_rd_o,
  output logic       is_wr_o,
  output logic       is_io_o,
  output logic [2:0] n_ts_o
);
  always_comb begin
    status_o = '0;
    is_rd_o  = 1'b0;
    is_wr_o  = 1'b0;
    n_ts_o   = 3'd3;
    unique case (kind_i)
      K_FETCH: begin status_o = 3'b011; is_rd_o = 1'b1; n_ts_o = long_i ? 3'd6 : 3'd4; end
      K_MRD:   begin status_o = 3'b010; is_rd_o = 1'b1; end
      K_MWR:   begin status_o = 3'b001; is_wr_o = 1'b1; end
      K_IORD:  begin status_o = 3'b110; is_rd_o = 1'b1; end
      K_IOWR:  begin status_o = 3'b101; is_wr_o = 1'b1; end
      default: ;
    endcase
    is_io_o = status_o.io_m;
  end
endmodule

// File: rtl/mbs_seq.sv
module mbs_seq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       last_i,
  input  logic [2:0] n_ts_i,
  output logic [2:0] ts_o,
  output logic       done_o
);
  logic [2:0] ts_q;
  logic       fin;

  assign fin = (ts_q != 3'd0) && last_i && (ts_q == n_ts_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q   <= 3'd0;
      done_o <= 1'b0;
    end else begin
      done_o <= fin;
      if (ts_q == 3'd0) begin
        if (start_i) ts_q <= 3'd1;
      end else if (last_i) begin
        ts_q <= fin ? 3'd0 : ts_q + 3'd1;
      end
    end
  end

  assign ts_o = ts_q;
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int TCLK_DIV = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [2:0]    req_kind_i,
  input  logic [2*DW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          req_long_i,
  output logic          busy_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic          io_m_o,
  output logic          s1_o,
  output logic          s0_o,
  output logic [DW-1:0] addr_hi_o,
  output logic          addr_hi_oe_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  localparam int AW = 2 * DW;

  logic [2:0]    kind_q;
  logic          long_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          start, first, last;
  logic [2:0]    ts, n_ts;
  logic          is_rd, is_wr, is_io, in_data;
  status_t       status;

  assign start = req_valid_i && !busy_o && kind_ok(req_kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= 3'd0;
      long_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      kind_q  <= req_kind_i;
      long_q  <= req_long_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  mbs_tick #(.DIV(TCLK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_o),
    .first_o(first), .last_o(last)
  );

  mbs_decode u_dec (
    .kind_i(kind_q), .long_i(long_q), .status_o(status),
    .is_rd_o(is_rd), .is_wr_o(is_wr), .is_io_o(is_io), .n_ts_o(n_ts)
  );

  mbs_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .last_i(last),
    .n_ts_i(n_ts), .ts_o(ts), .done_o(done_o)
  );

  assign busy_o  = (ts != 3'd0);
  assign in_data = (ts == 3'd2) || (ts == 3'd3);

  // strobes and enables decoded from the T-state
  assign ale_o        = (ts == 3'd1);
  assign addr_hi_oe_o = busy_o && (ts <= 3'd3);
  assign addr_hi_o    = is_io ? addr_q[DW-1:0] : addr_q[AW-1:DW];
  assign ad_oe_o      = ale_o || (is_wr && in_data);
  assign ad_o         = ale_o ? addr_q[DW-1:0] : wdata_q;
  assign rd_no        = !(is_rd && in_data);
  assign wr_no        = !(is_wr && ((ts == 3'd3) || (ts == 3'd2 && !first)));
  assign {io_m_o, s1_o, s0_o} = busy_o ? status : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_o <= '0;
    else if (is_rd && ts == 3'd3 && last) rdata_o <= ad_i;
  end
endmodule

// File: rtl/mbs_chk.sv
module mbs_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          ale_o,
  input logic          rd_no,
  input logic          wr_no,
  input logic          io_m_o,
  input logic          s1_o,
  input logic          s0_o,
  input logic          addr_hi_oe_o,
  input logic          ad_oe_o,
  input logic          done_o
);
  // R2
  ale_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (ad_oe_o && addr_hi_oe_o && busy_o));
  // R6
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (!ad_oe_o && wr_no));
  // R7
  wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> ad_oe_o);
  // R4
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable({io_m_o, s1_o, s0_o}));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  // R9
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> !$past(busy_o));
endmodule

bind mux_bus_seq mbs_chk #(.DW(DW)) u_mbs_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .ale_o(ale_o),
  .rd_no(rd_no), .wr_no(wr_no), .io_m_o(io_m_o), .s1_o(s1_o), .s0_o(s0_o),
  .addr_hi_oe_o(addr_hi_oe_o), .ad_oe_o(ad_oe_o), .done_o(done_o)
);

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_long = 1'b0;
  logic [7:0]  ad_in = '0;
  logic        busy, ale, rd_n, wr_n, io_m, s1, s0, hi_oe, ad_oe, done;
  logic [7:0]  addr_hi, ad_out, rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_long_i(req_long),
    .busy_o(busy), .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n), .io_m_o(io_m),
    .s1_o(s1), .s0_o(s0), .addr_hi_o(addr_hi), .addr_hi_oe_o(hi_oe),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    chk({busy, done, ale, rd_n, wr_n, ad_oe, hi_oe, io_m, s1, s0} == 10'b0001100000, req,
        {busy, done, ale, rd_n, wr_n, ad_oe, hi_oe, io_m, s1, s0}, 10'b0001100000);
  endtask

  task automatic run_cycle(input logic [2:0] kind, input logic [15:0] addr, input logic [7:0] wd,
                           input logic lng, input logic [7:0] rdv, input bit intrude);
    int   n;
    bit   is_rd, is_wr, is_io;
    logic [2:0] st;
    logic [7:0] hi_exp;
    n     = (kind == 3'd0) ? (lng ? 6 : 4) : 3;
    is_rd = (kind == 3'd0) || (kind == 3'd1) || (kind == 3'd3);
    is_wr = (kind == 3'd2) || (kind == 3'd4);
    is_io = (kind == 3'd3) || (kind == 3'd4);
    case (kind)
      3'd0: st = 3'b011;
      3'd1: st = 3'b010;
      3'd2: st = 3'b001;
      3'd3: st = 3'b110;
      default: st = 3'b101;
    endcase
    hi_exp = is_io ? addr[7:0] : addr[15:8];
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd; req_long = lng;
    ad_in = ~rdv;
    @(posedge clk);
    for (int c = 1; c <= 2 * n + 2; c++) begin
      int t;
      @(negedge clk);
      t = (c + 1) / 2;
      if (c == 1) req_valid = 1'b0;
      if (intrude && c == 3) begin req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'hFFFF; end
      if (intrude && c == 2 * n) req_valid = 1'b0;
      ad_in = (c == 6) ? rdv : ~rdv;
      if (c <= 2 * n) begin
        chk(ale == (t == 1), "R2", ale, (t == 1));
        chk(hi_oe == (t <= 3), "R3", hi_oe, (t <= 3));
        if (t <= 3) chk(addr_hi == hi_exp, is_io ? "R8" : "R3", addr_hi, hi_exp);
        if (t == 1) chk(ad_oe && ad_out == addr[7:0], is_io ? "R8" : "R3", {ad_oe, ad_out}, {1'b1, addr[7:0]});
        chk({io_m, s1, s0} == st, "R4", {io_m, s1, s0}, st);
        chk(busy && !done, "R5", {busy, done}, 2'b10);
        chk(rd_n == !(is_rd && (t == 2 || t == 3)), "R6", rd_n, !(is_rd && (t == 2 || t == 3)));
        if (is_rd && (t == 2 || t == 3)) chk(!ad_oe, "R6", ad_oe, 1'b0);
        chk(wr_n == !(is_wr && c >= 4 && c <= 6), "R7", wr_n, !(is_wr && c >= 4 && c <= 6));
        if (is_wr && (t == 2 || t == 3)) chk(ad_oe && ad_out == wd, "R7", {ad_oe, ad_out}, {1'b1, wd});
      end else if (c == 2 * n + 1) begin
        chk(done && !busy, "R5", {busy, done}, 2'b01);
        chk({ale, io_m, s1, s0, rd_n, wr_n} == 6'b000011, "R10", {ale, io_m, s1, s0, rd_n, wr_n}, 6'b000011);
        if (is_rd) chk(rdata == rdv, "R6", rdata, rdv);
      end else begin
        chk(!done, "R10", done, 1'b0);
        chk(!busy && !ale, "R9", {busy, ale}, 2'b00);
        if (is_rd) chk(rdata == rdv, "R10", rdata, rdv);
      end
    end
  endtask

  task automatic test_reset;
    // R1
    check_idle("R1");
    chk(rdata == 8'h00, "R1", rdata, 8'h00);
  endtask

  task automatic test_bad_kind;
    logic [7:0] keep;
    keep = rdata;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd7; req_addr = 16'h2222;
    repeat (3) @(negedge clk);
    // R9: kind 7 ignored
    check_idle("R9");
    req_kind = 3'd5;
    repeat (2) @(negedge clk);
    check_idle("R9");
    req_valid = 1'b0;
    @(negedge clk);
    check_idle("R9");
    chk(rdata == keep, "R10", rdata, keep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_cycle(3'd0, 16'h1234, 8'h00, 1'b0, 8'h3E, 1'b0);
    run_cycle(3'd0, 16'hABCD, 8'h00, 1'b1, 8'h81, 1'b0);
    run_cycle(3'd1, 16'h5A3C, 8'h00, 1'b0, 8'hC3, 1'b0);
    run_cycle(3'd2, 16'h0F80, 8'h96, 1'b0, 8'h11, 1'b0);
    run_cycle(3'd3, 16'hFF47, 8'h00, 1'b0, 8'h6D, 1'b0);
    run_cycle(3'd4, 16'h00E1, 8'h3D, 1'b0, 8'h22, 1'b0);
    run_cycle(3'd4, 16'h7F08, 8'hA5, 1'b0, 8'h44, 1'b1);
    run_cycle(3'd1, 16'h8001, 8'h00, 1'b0, 8'h5F, 1'b1);
    test_bad_kind();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule